// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit instruction into the control lines of a single-cycle datapath: register-file write enable, destination-register choice, ALU operand choice, data-memory read and write enables, write-back source choice, branch, jump and a 4-bit ALU operation code. The register file, memories and ALU sit outside the block. The datapath drives the opcode (instruction bits 31:26) and the function field (bits 5:0) into the decoder and uses the control word it returns.

The decode has two levels. The main decoder looks only at the opcode. It produces the single-bit controls and a 2-bit ALU class. A second decoder turns that class into the ALU operation code. It reads the function field only when the class says the operation is function-decoded. Any encoding that is not recognised yields a control word that changes no state. The control word is registered once, so it appears one clock after the fields are presented.

Top module: `ctrl_decoder`

## Requirements
- R1: While rst_n is low, every output is 0, including alu_op_o = 4'b0000.
- R2: The outputs reflect the opcode_i and funct_i values sampled at the previous rising edge of clk.
- R3: Opcode 6'h00 with a legal function code gives reg_we_o=1, dst_rd_o=1 (destination from bits 15:11), alu_imm_o=0, mem_rd_o=0, mem_we_o=0, mem_to_reg_o=0, branch_o=0, jump_o=0.
- R4: For opcode 6'h00, alu_op_o follows the function code: 6'h20 add gives 4'b0010, 6'h22 sub gives 4'b0110, 6'h24 and gives 4'b0000, 6'h25 or gives 4'b0001, 6'h26 xor gives 4'b0011, and 6'h2A set-less-than gives 4'b0111.
- R5: Opcode 6'h23 (load) gives reg_we_o=1, dst_rd_o=0 (destination from bits 20:16), alu_imm_o=1, mem_rd_o=1, mem_to_reg_o=1, mem_we_o=0, branch_o=0, jump_o=0, alu_op_o=4'b0010 (add).
- R6: Opcode 6'h2B (store) gives mem_we_o=1, alu_imm_o=1, alu_op_o=4'b0010. All other single-bit outputs are 0.
- R7: Opcode 6'h04 (branch-if-equal) gives branch_o=1, alu_op_o=4'b0110 (subtract). All other single-bit outputs are 0.
- R8: Opcode 6'h02 (jump) gives jump_o=1, alu_op_o=4'b0010. All other single-bit outputs are 0.
- R9: Any other opcode gives all single-bit outputs 0 and alu_op_o=4'b0010.
- R10: Opcode 6'h00 with a function code outside the six in R4 gives all single-bit outputs 0 and alu_op_o=4'b0010.
- R11: For every opcode other than 6'h00, funct_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Instruction bits 31:26 |
| funct_i | input | 6 | Instruction bits 5:0 |
| reg_we_o | output | 1 | Register-file write enable |
| dst_rd_o | output | 1 | 1: destination from bits 15:11; 0: from bits 20:16 |
| alu_imm_o | output | 1 | 1: ALU second operand is the sign-extended immediate |
| mem_rd_o | output | 1 | Data-memory read enable |
| mem_we_o | output | 1 | Data-memory write enable |
| mem_to_reg_o | output | 1 | 1: write-back data comes from memory |
| branch_o | output | 1 | Branch-if-equal instruction |
| jump_o | output | 1 | Jump instruction |
| alu_op_o | output | 4 | ALU operation code |

## Verification
The opcode decode and the function-field decode act in the same cycle for a register-type instruction. The main decoder grants the register write, and the second level can cancel it when the function code is illegal. The bench sends opcode 6'h00 with every legal function code and with several illegal ones back to back. It expects the write enable to drop only for the illegal codes. It also pairs each non-register opcode with function codes that would select a different ALU operation. Those results must match the opcode-only values.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 6;
    localparam int AOP_W = 4;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_XOR = 6'h26;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    localparam logic [AOP_W-1:0] AOP_AND = 4'b0000;
    localparam logic [AOP_W-1:0] AOP_OR  = 4'b0001;
    localparam logic [AOP_W-1:0] AOP_ADD = 4'b0010;
    localparam logic [AOP_W-1:0] AOP_XOR = 4'b0011;
    localparam logic [AOP_W-1:0] AOP_SUB = 4'b0110;
    localparam logic [AOP_W-1:0] AOP_SLT = 4'b0111;

    typedef enum logic [1:0] {
        CLS_ADD  = 2'b00,
        CLS_SUB  = 2'b01,
        CLS_FUNC = 2'b10
    } alu_class_e;

    typedef struct packed {
        logic              reg_we;
        logic              dst_rd;
        logic              alu_imm;
        logic              mem_rd;
        logic              mem_we;
        logic              mem_to_reg;
        logic              branch;
        logic              jump;
        logic [AOP_W-1:0]  alu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{default: 1'b0, alu_op: AOP_ADD};

endpackage

// File: rtl/ctrl_main_dec.sv
module ctrl_main_dec
    import ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output ctrl_t            ctl_o,
    output alu_class_e       cls_o,
    output logic             is_rtype_o
);

    always_comb begin
        ctl_o      = CTRL_IDLE;
        cls_o      = CLS_ADD;
        is_rtype_o = 1'b0;
        unique case (opcode_i)
            OPC_RTYPE: begin
                ctl_o.reg_we = 1'b1;
                ctl_o.dst_rd = 1'b1;
                cls_o        = CLS_FUNC;
                is_rtype_o   = 1'b1;
            end
            OPC_LOAD: begin
                ctl_o.reg_we     = 1'b1;
                ctl_o.alu_imm    = 1'b1;
                ctl_o.mem_rd     = 1'b1;
                ctl_o.mem_to_reg = 1'b1;
            end
            OPC_STORE: begin
                ctl_o.alu_imm = 1'b1;
                ctl_o.mem_we  = 1'b1;
            end
            OPC_BEQ: begin
                ctl_o.branch = 1'b1;
                cls_o        = CLS_SUB;
            end
            OPC_JUMP: begin
                ctl_o.jump = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ctrl_alu_dec.sv
module ctrl_alu_dec
    import ctrl_pkg::*;
(
    input  alu_class_e       cls_i,
    input  logic [FN_W-1:0]  funct_i,
    output logic [AOP_W-1:0] alu_op_o,
    output logic             fn_ok_o
);

    always_comb begin
        alu_op_o = AOP_ADD;
        fn_ok_o  = 1'b1;
        case (cls_i)
            CLS_SUB:  alu_op_o = AOP_SUB;
            CLS_FUNC: begin
                case (funct_i)
                    FN_ADD:  alu_op_o = AOP_ADD;
                    FN_SUB:  alu_op_o = AOP_SUB;
                    FN_AND:  alu_op_o = AOP_AND;
                    FN_OR:   alu_op_o = AOP_OR;
                    FN_XOR:  alu_op_o = AOP_XOR;
                    FN_SLT:  alu_op_o = AOP_SLT;
                    default: fn_ok_o  = 1'b0;
                endcase
            end
            default:  alu_op_o = AOP_ADD;
        endcase
    end

endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
    import ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [5:0]       opcode_i,
    input  logic [5:0]       funct_i,
    output logic             reg_we_o,
    output logic             dst_rd_o,
    output logic             alu_imm_o,
    output logic             mem_rd_o,
    output logic             mem_we_o,
    output logic             mem_to_reg_o,
    output logic             branch_o,
    output logic             jump_o,
    output logic [3:0]       alu_op_o
);

    ctrl_t            main_ctl;
    alu_class_e       main_cls;
    logic             main_rtype;
    logic [AOP_W-1:0] sub_op;
    logic             sub_ok;
    ctrl_t            ctrl_d;
    ctrl_t            ctrl_q;

    ctrl_main_dec i_main (
        .opcode_i   (opcode_i),
        .ctl_o      (main_ctl),
        .cls_o      (main_cls),
        .is_rtype_o (main_rtype)
    );

    ctrl_alu_dec i_alu (
        .cls_i    (main_cls),
        .funct_i  (funct_i),
        .alu_op_o (sub_op),
        .fn_ok_o  (sub_ok)
    );

    always_comb begin
        ctrl_d        = main_ctl;
        ctrl_d.alu_op = sub_op;
        if (main_rtype && !sub_ok) begin
            ctrl_d = CTRL_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign reg_we_o     = ctrl_q.reg_we;
    assign dst_rd_o     = ctrl_q.dst_rd;
    assign alu_imm_o    = ctrl_q.alu_imm;
    assign mem_rd_o     = ctrl_q.mem_rd;
    assign mem_we_o     = ctrl_q.mem_we;
    assign mem_to_reg_o = ctrl_q.mem_to_reg;
    assign branch_o     = ctrl_q.branch;
    assign jump_o       = ctrl_q.jump;
    assign alu_op_o     = ctrl_q.alu_op;

endmodule

// File: rtl/ctrl_decoder_chk.sv
module ctrl_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] opcode_i,
    input logic       reg_we_o,
    input logic       dst_rd_o,
    input logic       alu_imm_o,
    input logic       mem_rd_o,
    input logic       mem_we_o,
    input logic       mem_to_reg_o,
    input logic       branch_o,
    input logic       jump_o,
    input logic [3:0] alu_op_o
);

    logic op_known;
    assign op_known = (opcode_i == 6'h00) || (opcode_i == 6'h23) ||
                      (opcode_i == 6'h2B) || (opcode_i == 6'h04) ||
                      (opcode_i == 6'h02);

    // R5
    load_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i == 6'h23) |=> (reg_we_o && mem_rd_o && mem_to_reg_o &&
                                 alu_imm_o && !dst_rd_o && !mem_we_o));

    // R6
    store_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i == 6'h2B) |=> (mem_we_o && alu_imm_o && !reg_we_o && !mem_rd_o));

    // R7
    beq_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i == 6'h04) |=> (branch_o && alu_op_o == 4'b0110 &&
                                 !reg_we_o && !mem_we_o));

    // R8
    jump_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i == 6'h02) |=> (jump_o && !reg_we_o && !mem_we_o && !branch_o));

    // R9
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_known |=> (!reg_we_o && !mem_we_o && !branch_o && !jump_o && !mem_rd_o));

    // R3
    excl_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we_o, mem_we_o, branch_o, jump_o}));

    // R3
    wb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_to_reg_o |-> (mem_rd_o && reg_we_o));

endmodule

bind ctrl_decoder ctrl_decoder_chk i_ctrl_decoder_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .opcode_i     (opcode_i),
    .reg_we_o     (reg_we_o),
    .dst_rd_o     (dst_rd_o),
    .alu_imm_o    (alu_imm_o),
    .mem_rd_o     (mem_rd_o),
    .mem_we_o     (mem_we_o),
    .mem_to_reg_o (mem_to_reg_o),
    .branch_o     (branch_o),
    .jump_o       (jump_o),
    .alu_op_o     (alu_op_o)
);

// File: tb/test_ctrl_decoder.sv
`timescale 1ns/1ps
module test_ctrl_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode_i = '0;
    logic [5:0] funct_i = '0;
    logic       reg_we_o, dst_rd_o, alu_imm_o, mem_rd_o, mem_we_o;
    logic       mem_to_reg_o, branch_o, jump_o;
    logic [3:0] alu_op_o;

    int n_checks = 0;
    int n_errs   = 0;
    logic [11:0] exp_q[$];
    string       tag_q[$];
    bit          drv_done = 1'b0;

    always #2.5 clk = ~clk;

    ctrl_decoder i_ctrl_decoder (
        .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .funct_i(funct_i),
        .reg_we_o(reg_we_o), .dst_rd_o(dst_rd_o), .alu_imm_o(alu_imm_o),
        .mem_rd_o(mem_rd_o), .mem_we_o(mem_we_o), .mem_to_reg_o(mem_to_reg_o),
        .branch_o(branch_o), .jump_o(jump_o), .alu_op_o(alu_op_o)
    );

    // order: reg_we dst_rd alu_imm mem_rd mem_we mem_to_reg branch jump alu_op[3:0]
    function automatic logic [11:0] expected(input logic [5:0] op, input logic [5:0] fn);
        logic [11:0] idle;
        idle = {8'b0000_0000, 4'b0010};
        case (op)
            6'h00: begin
                case (fn)
                    6'h20: return {8'b1100_0000, 4'b0010};
                    6'h22: return {8'b1100_0000, 4'b0110};
                    6'h24: return {8'b1100_0000, 4'b0000};
                    6'h25: return {8'b1100_0000, 4'b0001};
                    6'h26: return {8'b1100_0000, 4'b0011};
                    6'h2A: return {8'b1100_0000, 4'b0111};
                    default: return idle;
                endcase
            end
            6'h23: return {8'b1011_0100, 4'b0010};
            6'h2B: return {8'b0010_1000, 4'b0010};
            6'h04: return {8'b0000_0010, 4'b0110};
            6'h02: return {8'b0000_0001, 4'b0010};
            default: return idle;
        endcase
    endfunction

    function automatic logic [11:0] observed();
        return {reg_we_o, dst_rd_o, alu_imm_o, mem_rd_o, mem_we_o,
                mem_to_reg_o, branch_o, jump_o, alu_op_o};
    endfunction

    task automatic drive(input logic [5:0] op, input logic [5:0] fn, input string tag);
        @(negedge clk);
        opcode_i = op;
        funct_i  = fn;
        exp_q.push_back(expected(op, fn));
        tag_q.push_back(tag);
    endtask

    // monitor: each item pushed before an edge is visible 1 ns after it (R2)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [11:0] e;
                string       t;
                logic [11:0] a;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = observed();
                n_checks++;
                if (a !== e) begin
                    n_errs++;
                    $display("FAIL %s R2: got %b expected %b", t, a, e);
                end
            end
        end
    end

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        n_errs++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        opcode_i = 6'h23;
        funct_i  = 6'h20;
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (observed() !== 12'h000) begin
            n_errs++;
            $display("FAIL R1 reset: got %b expected %b", observed(), 12'h000);
        end
        @(negedge clk);
        rst_n = 1'b1;

        drive(6'h00, 6'h20, "R3 R4 add");
        drive(6'h00, 6'h22, "R4 sub");
        drive(6'h00, 6'h24, "R4 and");
        drive(6'h00, 6'h25, "R4 or");
        drive(6'h00, 6'h26, "R4 xor");
        drive(6'h00, 6'h2A, "R4 slt");
        drive(6'h23, 6'h00, "R5 load");
        drive(6'h2B, 6'h00, "R6 store");
        drive(6'h04, 6'h00, "R7 beq");
        drive(6'h02, 6'h00, "R8 jump");
        drive(6'h3F, 6'h20, "R9 op3F");
        drive(6'h08, 6'h00, "R9 op08");
        drive(6'h01, 6'h2A, "R9 op01");
        drive(6'h05, 6'h22, "R9 op05");
        // legal and illegal function codes alternate back to back: R10
        drive(6'h00, 6'h00, "R10 fn00");
        drive(6'h00, 6'h25, "R3 after illegal");
        drive(6'h00, 6'h21, "R10 fn21");
        drive(6'h00, 6'h27, "R10 fn27");
        drive(6'h00, 6'h3F, "R10 fn3F");
        drive(6'h00, 6'h2A, "R3 after illegal2");
        // funct must not disturb other opcodes: R11
        drive(6'h23, 6'h22, "R11 load fn22");
        drive(6'h2B, 6'h24, "R11 store fn24");
        drive(6'h04, 6'h20, "R11 beq fn20");
        drive(6'h02, 6'h2A, "R11 jump fn2A");
        drive(6'h23, 6'h3F, "R11 load fn3F");
        for (int k = 0; k < 64; k++) begin
            drive(6'h2B, k[5:0], "R11 store sweep");
        end
        for (int k = 0; k < 64; k++) begin
            drive(k[5:0], 6'h26, "R9 opcode sweep");
        end
        for (int k = 0; k < 64; k++) begin
            drive(6'h00, k[5:0], "R10 funct sweep");
        end
        drive_done_wait();
    end

    task automatic drive_done_wait();
        repeat (3) @(posedge clk);
        #1;
        if (exp_q.size() != 0) begin
            n_errs++;
            n_checks++;
            $display("FAIL R2 queue: got %0d pending expected 0", exp_q.size());
        end
        drv_done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

endmodule